// File: doc/BRIEF.md
# Two-Wire Serial Memory Slave with Write Gate

This block is the bidirectional side of a small serial memory. It answers on a two-wire bus once a separate streaming mode has been left, which is signalled by the `mode_en` input. A bus master opens each transaction with a START condition and sends a device select byte. Only device select bytes whose upper nibble is 1010 get a reply. The lowest bit of that byte picks the direction. A write transaction first sets a word pointer and then stores data bytes at successive locations. A read transaction returns bytes from the pointer onwards for as long as the master acknowledges them.

The bus lines are sampled with a fast system clock, which must run several times faster than SCL. SDA is driven only low, through an open-drain enable. The memory array sits outside the block. It is reached through a combinational read port and a one-cycle write strobe. A separate `wr_en` input gates every store. While `wr_en` is low, data bytes are still acknowledged and the pointer still moves, but nothing reaches the array.

Top module: `eeprom_2w_slave`

## Requirements
- R1: After reset, and whenever `mode_en` is low, `sda_oe` and `mem_we` stay 0, and bus traffic gets no acknowledge.
- R2: A START is SDA falling while SCL is high, and it begins a device select. A STOP is SDA rising while SCL is high; it returns the block to idle with SDA released, leaving the pointer unchanged.
- R3: A device select byte whose bits 7:4 equal 1010 is acknowledged by pulling SDA low in the ninth bit time. Any other code is not acknowledged, and the block gives no acknowledge to any byte until the next START.
- R4: In a write transaction (device select bit 0 = 0), the first byte after the device select loads the 7-bit word pointer from its bits 6:0, and it is acknowledged.
- R5: Each further write byte is acknowledged. It is stored with a single-cycle `mem_we` pulse at the pointer, and the pointer then increments modulo 128, so address 127 is followed by 0.
- R6: While `wr_en` is 0 when a data byte completes, no `mem_we` pulse occurs. The byte is still acknowledged and the pointer still advances.
- R7: In a read transaction (device select bit 0 = 1), the block sends the byte at the pointer MSB first, starting right after its acknowledge. The pointer increments modulo 128 for each byte sent.
- R8: A master acknowledge (SDA low in the ninth bit) makes the block send the next byte. A missing acknowledge (SDA high) ends output, and SDA stays released until the next START.
- R9: A START that arrives in the middle of a transaction (a repeated START) abandons that transaction and begins a new device select, keeping the pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Active-low asynchronous reset (power-on reset) |
| mode_en | input | 1 | High once bidirectional operation is active |
| wr_en | input | 1 | Write gate; stores happen only while high |
| scl_i | input | 1 | Serial clock from the bus |
| sda_i | input | 1 | Serial data as seen on the bus |
| sda_oe | output | 1 | When 1, pull SDA low |
| mem_addr | output | 7 | Memory address (write address during a strobe, else the pointer) |
| mem_wdata | output | 8 | Data to store |
| mem_we | output | 1 | One-cycle store strobe |
| mem_rdata | input | 8 | Combinational read data at `mem_addr` |

## Verification
A store into location 127 and the wrap of the pointer to 0 fall in the same clock cycle. The bench provokes this by setting the pointer to 0x7F and writing two bytes in one transaction. It judges the result by checking that the first byte lands at 0x7F and the second at 0x00, and later by reading both locations back in one sequential read. In the same way, the gated write and the pointer advance coincide when `wr_en` is low. The bench checks that case by confirming that the array is untouched and that a following read starts two locations further on.

// File: rtl/tws_pkg.sv
package tws_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RX,
        ST_ACK,
        ST_TX,
        ST_MACK,
        ST_HOLD
    } eng_state_e;

    typedef enum logic [1:0] {
        K_DEV,
        K_WADDR,
        K_WDATA
    } rx_kind_e;
endpackage

// File: rtl/tws_line_sync.sv
module tws_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_lvl,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    typedef struct packed {
        logic [STAGES-1:0] scl_sr;
        logic [STAGES-1:0] sda_sr;
        logic              scl_p;
        logic              sda_p;
    } sync_s;

    sync_s s_q, s_d;
    logic  scl_now, sda_now;

    assign scl_now = s_q.scl_sr[STAGES-1];
    assign sda_now = s_q.sda_sr[STAGES-1];

    always_comb begin
        s_d        = s_q;
        s_d.scl_sr = {s_q.scl_sr[STAGES-2:0], scl_i};
        s_d.sda_sr = {s_q.sda_sr[STAGES-2:0], sda_i};
        s_d.scl_p  = scl_now;
        s_d.sda_p  = sda_now;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '1;
        else        s_q <= s_d;
    end

    // bus conditions, all from registered samples
    assign sda_lvl   = sda_now;
    assign scl_rise  = ~s_q.scl_p & scl_now;
    assign scl_fall  = s_q.scl_p & ~scl_now;
    assign start_det = s_q.scl_p & scl_now & s_q.sda_p & ~sda_now;
    assign stop_det  = s_q.scl_p & scl_now & ~s_q.sda_p & sda_now;
endmodule

// File: rtl/tws_engine.sv
module tws_engine
    import tws_pkg::*;
#(
    parameter int          AW       = 7,
    parameter int          DW       = 8,
    parameter logic [3:0]  DEV_CODE = 4'b1010
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          active,
    input  logic          wr_en,
    input  logic          scl_rise,
    input  logic          scl_fall,
    input  logic          start_det,
    input  logic          stop_det,
    input  logic          sda_lvl,
    input  logic [DW-1:0] mem_rdata,
    output logic          sda_oe,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [DW-1:0] mem_wdata
);
    localparam int CW = $clog2(DW + 1);
    localparam logic [CW-1:0] FULL = CW'(DW);
    localparam logic [CW-1:0] LAST = CW'(DW - 1);

    typedef struct packed {
        eng_state_e    st;
        rx_kind_e      kind;
        logic [CW-1:0] cnt;
        logic [DW-1:0] sh;
        logic          rw;
        logic [AW-1:0] ptr;
        logic [AW-1:0] wa;
        logic [DW-1:0] wd;
        logic          we;
        logic          oe;
    } eng_s;

    eng_s r_q, r_d;

    always_comb begin
        r_d    = r_q;
        r_d.we = 1'b0;
        if (!active) begin
            r_d.st = ST_IDLE;
            r_d.oe = 1'b0;
        end else if (start_det) begin
            r_d.st   = ST_RX;
            r_d.kind = K_DEV;
            r_d.cnt  = '0;
            r_d.oe   = 1'b0;
        end else if (stop_det) begin
            r_d.st = ST_IDLE;
            r_d.oe = 1'b0;
        end else begin
            unique case (r_q.st)
                ST_RX: begin
                    if (scl_rise && r_q.cnt < FULL) begin
                        r_d.sh  = {r_q.sh[DW-2:0], sda_lvl};
                        r_d.cnt = r_q.cnt + CW'(1);
                    end else if (scl_fall && r_q.cnt == FULL) begin
                        unique case (r_q.kind)
                            K_DEV: begin
                                if (r_q.sh[DW-1 -: 4] == DEV_CODE) begin
                                    r_d.rw = r_q.sh[0];
                                    r_d.st = ST_ACK;
                                    r_d.oe = 1'b1;
                                end else begin
                                    r_d.st = ST_HOLD;
                                end
                            end
                            K_WADDR: begin
                                r_d.ptr = r_q.sh[AW-1:0];
                                r_d.st  = ST_ACK;
                                r_d.oe  = 1'b1;
                            end
                            default: begin
                                r_d.wa  = r_q.ptr;
                                r_d.wd  = r_q.sh;
                                r_d.we  = wr_en;
                                r_d.ptr = r_q.ptr + AW'(1);
                                r_d.st  = ST_ACK;
                                r_d.oe  = 1'b1;
                            end
                        endcase
                    end
                end
                ST_ACK: begin
                    if (scl_fall) begin
                        r_d.cnt = '0;
                        if (r_q.kind == K_DEV && r_q.rw) begin
                            r_d.sh  = mem_rdata;
                            r_d.ptr = r_q.ptr + AW'(1);
                            r_d.oe  = ~mem_rdata[DW-1];
                            r_d.st  = ST_TX;
                        end else begin
                            r_d.oe   = 1'b0;
                            r_d.st   = ST_RX;
                            r_d.kind = (r_q.kind == K_DEV) ? K_WADDR : K_WDATA;
                        end
                    end
                end
                ST_TX: begin
                    if (scl_fall) begin
                        if (r_q.cnt == LAST) begin
                            r_d.oe = 1'b0;
                            r_d.st = ST_MACK;
                        end else begin
                            r_d.sh  = {r_q.sh[DW-2:0], 1'b0};
                            r_d.oe  = ~r_q.sh[DW-2];
                            r_d.cnt = r_q.cnt + CW'(1);
                        end
                    end
                end
                ST_MACK: begin
                    if (scl_rise && sda_lvl) begin
                        r_d.st = ST_HOLD;
                    end else if (scl_fall) begin
                        r_d.sh  = mem_rdata;
                        r_d.ptr = r_q.ptr + AW'(1);
                        r_d.oe  = ~mem_rdata[DW-1];
                        r_d.cnt = '0;
                        r_d.st  = ST_TX;
                    end
                end
                default: r_d.oe = 1'b0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q      <= '0;
            r_q.st   <= ST_IDLE;
            r_q.kind <= K_DEV;
        end else begin
            r_q <= r_d;
        end
    end

    assign sda_oe    = r_q.oe;
    assign mem_we    = r_q.we;
    assign mem_wdata = r_q.wd;
    assign mem_addr  = r_q.we ? r_q.wa : r_q.ptr;
endmodule

// File: rtl/eeprom_2w_slave.sv
module eeprom_2w_slave #(
    parameter int         ADDR_W      = 7,
    parameter int         DATA_W      = 8,
    parameter int         SYNC_STAGES = 2,
    parameter logic [3:0] DEV_CODE    = 4'b1010
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_en,
    input  logic              wr_en,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_oe,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    output logic              mem_we,
    input  logic [DATA_W-1:0] mem_rdata
);
    logic sda_lvl, scl_rise_w, scl_fall_w, start_w, stop_w;

    tws_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .sda_lvl   (sda_lvl),
        .scl_rise  (scl_rise_w),
        .scl_fall  (scl_fall_w),
        .start_det (start_w),
        .stop_det  (stop_w)
    );

    tws_engine #(.AW(ADDR_W), .DW(DATA_W), .DEV_CODE(DEV_CODE)) u_eng (
        .clk       (clk),
        .rst_n     (rst_n),
        .active    (mode_en),
        .wr_en     (wr_en),
        .scl_rise  (scl_rise_w),
        .scl_fall  (scl_fall_w),
        .start_det (start_w),
        .stop_det  (stop_w),
        .sda_lvl   (sda_lvl),
        .mem_rdata (mem_rdata),
        .sda_oe    (sda_oe),
        .mem_we    (mem_we),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata)
    );
endmodule

// File: rtl/tws_chk.sv
module tws_chk (
    input logic clk,
    input logic rst_n,
    input logic mode_en,
    input logic wr_en,
    input logic scl_fall,
    input logic stop_det,
    input logic sda_oe,
    input logic mem_we
);
    // R1
    inactive_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mode_en |=> !sda_oe);

    // R1
    inactive_nowrite_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mode_en |=> !mem_we);

    // R2
    stop_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> !sda_oe);

    // R3
    drive_after_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_oe) |-> $past(scl_fall));

    // R5
    single_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |=> !mem_we);

    // R6
    gated_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> $past(wr_en));
endmodule

bind eeprom_2w_slave tws_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .mode_en  (mode_en),
    .wr_en    (wr_en),
    .scl_fall (scl_fall_w),
    .stop_det (stop_w),
    .sda_oe   (sda_oe),
    .mem_we   (mem_we)
);

// File: tb/tb_eeprom_2w_slave.sv
module tb_eeprom_2w_slave;
    localparam int CLK_NS = 10;
    localparam int HB     = 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       mode_en = 1'b0;
    logic       wr_en = 1'b1;
    logic       m_scl = 1'b1;
    logic       m_sda = 1'b1;
    logic       sda_bus;
    logic       sda_oe;
    logic [6:0] mem_addr;
    logic [7:0] mem_wdata;
    logic       mem_we;
    logic [7:0] mem_rdata;
    logic [7:0] mem [128];
    int         errors = 0;
    int         checks = 0;
    int         writes = 0;
    bit         done = 1'b0;

    always #(CLK_NS/2) clk = ~clk;

    assign sda_bus   = m_sda & ~sda_oe;
    assign mem_rdata = mem[mem_addr];

    always @(posedge clk) begin
        if (mem_we) begin
            mem[mem_addr] <= mem_wdata;
            writes <= writes + 1;
        end
    end

    eeprom_2w_slave dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .mode_en   (mode_en),
        .wr_en     (wr_en),
        .scl_i     (m_scl),
        .sda_i     (sda_bus),
        .sda_oe    (sda_oe),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .mem_we    (mem_we),
        .mem_rdata (mem_rdata)
    );

    function automatic logic [7:0] pat(input int i);
        return 8'(i * 7) ^ 8'h5C;
    endfunction

    task automatic w(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic bus_start();
        m_sda = 1'b1; w(HB);
        m_scl = 1'b1; w(HB);
        m_sda = 1'b0; w(HB);
        m_scl = 1'b0; w(HB);
    endtask

    task automatic bus_stop();
        m_sda = 1'b0; w(HB);
        m_scl = 1'b1; w(HB);
        m_sda = 1'b1; w(HB);
    endtask

    task automatic put_byte(input logic [7:0] b, output logic ack);
        for (int i = 7; i >= 0; i--) begin
            m_sda = b[i]; w(HB);
            m_scl = 1'b1; w(HB);
            m_scl = 1'b0; w(2);
        end
        m_sda = 1'b1; w(HB);
        m_scl = 1'b1; w(HB/2);
        ack = sda_bus; w(HB/2);
        m_scl = 1'b0; w(2);
    endtask

    task automatic get_byte(input logic mack, output logic [7:0] b);
        m_sda = 1'b1;
        b = '0;
        for (int i = 0; i < 8; i++) begin
            w(HB);
            m_scl = 1'b1; w(HB/2);
            b = {b[6:0], sda_bus}; w(HB/2);
            m_scl = 1'b0;
        end
        w(2);
        m_sda = mack; w(HB);
        m_scl = 1'b1; w(HB);
        m_scl = 1'b0; w(2);
        m_sda = 1'b1;
    endtask

    task automatic t_reset();
        check("R1 reset sda_oe", 32'(sda_oe), 0);
        check("R1 reset mem_we", 32'(mem_we), 0);
    endtask

    task automatic t_inactive();
        logic a;
        mode_en = 1'b0;
        bus_start();
        put_byte(8'hA0, a);
        check("R1 no ack while inactive", 32'(a), 1);
        put_byte(8'h05, a);
        bus_stop();
        check("R1 no write while inactive", writes, 0);
        mode_en = 1'b1; w(4);
    endtask

    task automatic t_bad_code();
        logic a;
        bus_start();
        put_byte(8'h90, a);
        check("R3 wrong code not acked", 32'(a), 1);
        put_byte(8'h00, a);
        check("R3 silent until next START", 32'(a), 1);
        bus_stop();
    endtask

    task automatic t_write();
        logic a;
        int   wb = writes;
        bus_start();
        put_byte(8'hA0, a);
        check("R3 device select acked", 32'(a), 0);
        put_byte(8'h10, a);
        check("R4 word address acked", 32'(a), 0);
        put_byte(8'h5A, a);
        check("R5 data byte 1 acked", 32'(a), 0);
        put_byte(8'hC3, a);
        check("R5 data byte 2 acked", 32'(a), 0);
        bus_stop();
        check("R5 stored at 0x10", 32'(mem[16]), 32'h5A);
        check("R5 stored at 0x11", 32'(mem[17]), 32'hC3);
        check("R5 two strobes", writes - wb, 2);
    endtask

    task automatic t_wrap();
        logic a;
        bus_start();
        put_byte(8'hA0, a);
        put_byte(8'h7F, a);
        put_byte(8'h11, a);
        put_byte(8'h22, a);
        bus_stop();
        check("R5 stored at 0x7F", 32'(mem[127]), 32'h11);
        check("R5 wrapped to 0x00", 32'(mem[0]), 32'h22);
    endtask

    task automatic t_gate();
        logic       a;
        logic [7:0] b;
        int         wb = writes;
        wr_en = 1'b0;
        bus_start();
        put_byte(8'hA0, a);
        put_byte(8'h20, a);
        put_byte(8'hEE, a);
        check("R6 gated byte still acked", 32'(a), 0);
        put_byte(8'h77, a);
        bus_stop();
        check("R6 no strobe while gated", writes - wb, 0);
        check("R6 array untouched", 32'(mem[32]), 32'(pat(32)));
        wr_en = 1'b1;
        bus_start();
        put_byte(8'hA1, a);
        get_byte(1'b1, b);
        bus_stop();
        check("R6 pointer advanced past gated bytes", 32'(b), 32'(pat(34)));
    endtask

    task automatic t_read_seq();
        logic       a;
        logic [7:0] b;
        bus_start();
        put_byte(8'hA0, a);
        put_byte(8'h7E, a);
        bus_start();
        put_byte(8'hA1, a);
        check("R9 repeated START device select acked", 32'(a), 0);
        get_byte(1'b0, b);
        check("R7 read at 0x7E", 32'(b), 32'(pat(126)));
        get_byte(1'b0, b);
        check("R8 acked read continues at 0x7F", 32'(b), 32'h11);
        get_byte(1'b1, b);
        check("R7 read wraps to 0x00", 32'(b), 32'h22);
        get_byte(1'b1, b);
        check("R8 released after missing ack", 32'(b), 32'hFF);
        bus_stop();
        w(4);
        check("R2 released after STOP", 32'(sda_oe), 0);
    endtask

    task automatic t_stop_keeps_ptr();
        logic       a;
        logic [7:0] b;
        bus_start();
        put_byte(8'hA0, a);
        put_byte(8'h30, a);
        bus_stop();
        bus_start();
        put_byte(8'hA1, a);
        get_byte(1'b1, b);
        bus_stop();
        check("R4 R2 pointer loaded and kept over STOP", 32'(b), 32'(pat(48)));
    endtask

    initial begin
        for (int i = 0; i < 128; i++) mem[i] = pat(i);
        w(5);
        t_reset();
        rst_n = 1'b1;
        w(5);
        t_inactive();
        t_bad_code();
        t_write();
        t_wrap();
        t_gate();
        t_read_seq();
        t_stop_keeps_ptr();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule